// File: doc/BRIEF.md
# Dot-Matrix Row Scan Sequencer

This block generates the refresh timing for an eight-character 5x7 LED dot-matrix panel. The panel has 20 column lines shared by two banks of seven row lines. Bank 0 serves characters 0 to 3 and bank 1 serves characters 4 to 7. Each character covers five of the twenty columns. The sequencer steps through 14 row phases, with the two banks interleaved. For every phase it reports the active row, the active bank and the first character index of that bank, so the font lookup knows which glyph rows to fetch. Each phase is split into equal sub-slots, which dimming logic can use to gate the columns for part of the phase.

The scan is driven by a base tick. The tick comes from one of two sources. The first is an internal oscillator, which is a divider on the system clock. The second is an external scan clock from a neighbouring unit. When the internal source is chosen, the oscillator's square wave is driven out, so other units can run from it. A shared synchronous reset clears every counter. Several units that share a reset and a scan clock therefore stay in step, and so does their slow blink signal. The blink signal is a 50% duty square wave produced by dividing the completed refresh count.

Top module: `scan_sequencer`

## Requirements
- R1: After a clock edge that samples `rst_n` low, every output is zero: `row_idx`, `bank_idx`, `digit_base`, `sub_slot`, `phase_strobe`, `blink` and `osc_out`.
- R2: With `clk_sel` high, the base tick comes from the internal divider. The divider's first tick is used at edge OSC_HALF after reset, and after that at every 2*OSC_HALF edges. `osc_out` is then a square wave that toggles every OSC_HALF clock cycles, starting low.
- R3: With `clk_sel` low, `ext_clk` passes through two synchronizing flops. Each rising edge of `ext_clk` counts as exactly one base tick, and that tick is used at the third `clk` edge after the pin rises. `osc_out` is held low.
- R4: `sub_slot` advances by one on every base tick. It counts 0 to SUBSLOTS-1 and then wraps to 0, and the wrap ends the current phase.
- R5: The phases run in a fixed order. Phase p (0 to 13) has bank = p mod 2 and row = p div 2. The bank alternates at every phase, the row advances after bank 1, and phase 13 wraps to phase 0.
- R6: `digit_base` equals bank times 4. It is 0 for bank 0 and 4 for bank 1, and it is registered together with the bank.
- R7: `phase_strobe` is high for exactly the one cycle after each edge that starts a new phase.
- R8: `blink` toggles at the edge that completes every BLINK_FRAMES-th full refresh of 14 phases, which gives a 50% duty square wave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset, shared between units |
| clk_sel | input | 1 | 1: internal oscillator, 0: external scan clock |
| ext_clk | input | 1 | External scan clock from another unit (asynchronous) |
| osc_out | output | 1 | Internal oscillator level when clk_sel is 1, else 0 |
| row_idx | output | 3 | Active row within the bank, 0..6 (font row address) |
| bank_idx | output | 1 | Active row bank, 0 or 1 |
| digit_base | output | 3 | First character index served by the active bank |
| sub_slot | output | 4 | Sub-slot within the current phase, 0..SUBSLOTS-1 |
| phase_strobe | output | 1 | One-cycle pulse after each phase change |
| blink | output | 1 | Slow 50% duty attribute square wave |

## Verification
With the internal source, the first base tick lands at edge OSC_HALF after the reset edge and then at every 2*OSC_HALF edges. With the external source, a rising edge that the bench drives between clock edges is consumed three edges later. The registered outputs and the strobe change at the same edge that consumes the tick, and `blink` changes at the edge that ends the last phase of a refresh. At every clock edge, the bench derives the number of ticks consumed so far from these closed-form latencies and pushes the full expected output set into a queue. A monitor pops each entry two time units after the edge and compares it field by field, so every result is checked in the exact cycle it is due. This holds across a reset in mid-run and across a change of clock source.

// File: rtl/scan_seq_pkg.sv
// Shared types and helpers for the row scan sequencer.
// Assumes nothing beyond IEEE 1800-2017 constant functions.
package scan_seq_pkg;

    // Encoding of the clock-source select pin.
    typedef enum logic {
        SRC_EXT = 1'b0,
        SRC_INT = 1'b1
    } clk_src_e;

    // Bit width that holds 0..n-1, never less than one bit.
    function automatic int width_of(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/scan_clk_src.sv
// Base tick generator. Runs an internal oscillator (a divider that toggles
// its level every OSC_HALF clk cycles) and a two-flop synchronizer with edge
// detect for an external scan clock. It picks one of them as a one-cycle
// base tick. Assumes OSC_HALF >= 2 and that clk_sel only changes while
// rst_n is low.
module scan_clk_src
    import scan_seq_pkg::*;
#(
    parameter int OSC_HALF = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_sel,
    input  logic ext_clk,
    output logic base_tick,
    output logic osc_out
);

    localparam int             CW       = width_of(OSC_HALF);
    localparam logic [CW-1:0]  CNT_LAST = CW'(OSC_HALF - 1);

    logic [CW-1:0] div_cnt;
    logic          osc_q;
    logic [2:0]    ext_sh;
    logic          int_tick;
    logic          ext_tick;
    clk_src_e      src;

    // Internal oscillator: count half periods and toggle the level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            osc_q   <= 1'b0;
        end else if (div_cnt == CNT_LAST) begin
            div_cnt <= '0;
            osc_q   <= ~osc_q;
        end else begin
            div_cnt <= div_cnt + CW'(1);
        end
    end

    // External clock: two synchronizing stages plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_sh <= '0;
        end else begin
            ext_sh <= {ext_sh[1:0], ext_clk};
        end
    end

    // Source selection and rising-edge tick generation.
    always_comb begin
        src       = clk_src_e'(clk_sel);
        int_tick  = (div_cnt == CNT_LAST) && !osc_q;
        ext_tick  = ext_sh[1] && !ext_sh[2];
        base_tick = (src == SRC_INT) ? int_tick : ext_tick;
        osc_out   = (src == SRC_INT) ? osc_q : 1'b0;
    end

endmodule

// File: rtl/scan_phase_ctr.sv
// Phase sequencer. On each base tick it advances the sub-slot counter. When
// the sub-slot wraps, it moves to the next row phase: the bank alternates
// first, and the row advances after the last bank. It registers the row,
// the bank and the bank's first character index, and pulses a strobe for
// one cycle. It also flags the tick that ends a full refresh.
// Assumes SUBSLOTS >= 2 and that DIGITS is a multiple of BANKS.
module scan_phase_ctr
    import scan_seq_pkg::*;
#(
    parameter int SUBSLOTS = 15,
    parameter int ROWS     = 7,
    parameter int BANKS    = 2,
    parameter int DIGITS   = 8,
    localparam int SW      = width_of(SUBSLOTS),
    localparam int RW      = width_of(ROWS),
    localparam int BW      = width_of(BANKS),
    localparam int DW      = width_of(DIGITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    output logic [SW-1:0] sub_slot,
    output logic [RW-1:0] row_idx,
    output logic [BW-1:0] bank_idx,
    output logic [DW-1:0] digit_base,
    output logic          phase_strobe,
    output logic          frame_end
);

    localparam int DPB = DIGITS / BANKS;

    logic          sub_last;
    logic          row_last;
    logic          bank_last;
    logic [RW-1:0] row_nxt;
    logic [BW-1:0] bank_nxt;
    logic [DW-1:0] dbase_nxt;

    // Position of the next phase in bank-interleaved order.
    always_comb begin
        sub_last  = (sub_slot == SW'(SUBSLOTS - 1));
        row_last  = (row_idx  == RW'(ROWS - 1));
        bank_last = (bank_idx == BW'(BANKS - 1));
        row_nxt   = row_idx;
        bank_nxt  = bank_idx;
        if (bank_last) begin
            bank_nxt = '0;
            row_nxt  = row_last ? '0 : row_idx + RW'(1);
        end else begin
            bank_nxt = bank_idx + BW'(1);
        end
        dbase_nxt = DW'(int'(bank_nxt) * DPB);
        frame_end = tick && sub_last && bank_last && row_last;
    end

    // Sub-slot counter and registered phase outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_slot     <= '0;
            row_idx      <= '0;
            bank_idx     <= '0;
            digit_base   <= '0;
            phase_strobe <= 1'b0;
        end else begin
            phase_strobe <= 1'b0;
            if (tick) begin
                if (sub_last) begin
                    sub_slot     <= '0;
                    row_idx      <= row_nxt;
                    bank_idx     <= bank_nxt;
                    digit_base   <= dbase_nxt;
                    phase_strobe <= 1'b1;
                end else begin
                    sub_slot <= sub_slot + SW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/scan_blink_div.sv
// Attribute blink divider. It counts completed refreshes and toggles the
// blink level every BLINK_FRAMES of them, which gives a 50% duty square
// wave. Assumes frame_end is a one-cycle pulse.
module scan_blink_div
    import scan_seq_pkg::*;
#(
    parameter int BLINK_FRAMES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_end,
    output logic blink
);

    localparam int            FW      = width_of(BLINK_FRAMES);
    localparam logic [FW-1:0] FR_LAST = FW'(BLINK_FRAMES - 1);

    logic [FW-1:0] frame_cnt;

    // Refresh counter that toggles blink on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_cnt <= '0;
            blink     <= 1'b0;
        end else if (frame_end) begin
            if (frame_cnt == FR_LAST) begin
                frame_cnt <= '0;
                blink     <= ~blink;
            end else begin
                frame_cnt <= frame_cnt + FW'(1);
            end
        end
    end

endmodule

// File: rtl/scan_sequencer.sv
// Top of the row/column scan sequencer. It chains the clock source, the
// phase sequencer and the blink divider. All state resets synchronously,
// so units that share rst_n and a scan clock stay in lock-step.
module scan_sequencer
    import scan_seq_pkg::*;
#(
    parameter int OSC_HALF     = 16,
    parameter int SUBSLOTS     = 15,
    parameter int ROWS         = 7,
    parameter int BANKS        = 2,
    parameter int DIGITS       = 8,
    parameter int BLINK_FRAMES = 8,
    localparam int SW          = width_of(SUBSLOTS),
    localparam int RW          = width_of(ROWS),
    localparam int BW          = width_of(BANKS),
    localparam int DW          = width_of(DIGITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_sel,
    input  logic          ext_clk,
    output logic          osc_out,
    output logic [RW-1:0] row_idx,
    output logic [BW-1:0] bank_idx,
    output logic [DW-1:0] digit_base,
    output logic [SW-1:0] sub_slot,
    output logic          phase_strobe,
    output logic          blink
);

    logic base_tick;
    logic frame_end;

    scan_clk_src #(
        .OSC_HALF (OSC_HALF)
    ) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_sel   (clk_sel),
        .ext_clk   (ext_clk),
        .base_tick (base_tick),
        .osc_out   (osc_out)
    );

    scan_phase_ctr #(
        .SUBSLOTS (SUBSLOTS),
        .ROWS     (ROWS),
        .BANKS    (BANKS),
        .DIGITS   (DIGITS)
    ) u_phase (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (base_tick),
        .sub_slot     (sub_slot),
        .row_idx      (row_idx),
        .bank_idx     (bank_idx),
        .digit_base   (digit_base),
        .phase_strobe (phase_strobe),
        .frame_end    (frame_end)
    );

    scan_blink_div #(
        .BLINK_FRAMES (BLINK_FRAMES)
    ) u_blink (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .blink     (blink)
    );

endmodule

// File: rtl/scan_sequencer_chk.sv
// Property checker for scan_sequencer, attached by bind. It observes only
// the top-level ports. Assumes BANKS == 2 for the bank alternation check.
module scan_sequencer_chk
    import scan_seq_pkg::*;
#(
    parameter int SUBSLOTS = 15,
    parameter int ROWS     = 7,
    parameter int BANKS    = 2,
    parameter int DIGITS   = 8,
    localparam int SW      = width_of(SUBSLOTS),
    localparam int RW      = width_of(ROWS),
    localparam int BW      = width_of(BANKS),
    localparam int DW      = width_of(DIGITS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_sel,
    input logic          osc_out,
    input logic [RW-1:0] row_idx,
    input logic [BW-1:0] bank_idx,
    input logic [DW-1:0] digit_base,
    input logic [SW-1:0] sub_slot,
    input logic          phase_strobe,
    input logic          blink
);

    localparam int DPB = DIGITS / BANKS;

    // R3: external source keeps the oscillator output low.
    assert_ext_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_sel |-> !osc_out);

    // R4: a new phase always starts at sub-slot zero.
    assert_strobe_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        phase_strobe |-> (sub_slot == '0));

    // R4: the sub-slot only steps up by one or wraps to zero.
    assert_slot_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (sub_slot != $past(sub_slot)))
        |-> ((sub_slot == $past(sub_slot) + SW'(1)) || (sub_slot == '0)));

    // R5: the bank changes at every phase.
    assert_bank_alt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && phase_strobe) |-> (bank_idx != $past(bank_idx)));

    // R5: entering bank 0 advances the row, wrapping after the last row.
    assert_row_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && phase_strobe && (bank_idx == '0))
        |-> (row_idx == (($past(row_idx) == RW'(ROWS - 1)) ? '0
                                                          : $past(row_idx) + RW'(1))));

    // R5: entering a later bank keeps the row.
    assert_row_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && phase_strobe && (bank_idx != '0))
        |-> (row_idx == $past(row_idx)));

    // R5: the row never leaves its range.
    assert_row_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(row_idx) < ROWS);

    // R6: the first character index tracks the bank.
    assert_digit_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(digit_base) == int'(bank_idx) * DPB);

    // R7: the phase strobe lasts one cycle.
    assert_strobe_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        phase_strobe |=> !phase_strobe);

    // R8: blink changes only on entry to phase 0.
    assert_blink_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (blink != $past(blink)))
        |-> (phase_strobe && (row_idx == '0) && (bank_idx == '0)));

endmodule

bind scan_sequencer scan_sequencer_chk #(
    .SUBSLOTS (SUBSLOTS),
    .ROWS     (ROWS),
    .BANKS    (BANKS),
    .DIGITS   (DIGITS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_sel      (clk_sel),
    .osc_out      (osc_out),
    .row_idx      (row_idx),
    .bank_idx     (bank_idx),
    .digit_base   (digit_base),
    .sub_slot     (sub_slot),
    .phase_strobe (phase_strobe),
    .blink        (blink)
);

// File: tb/sim_scan_sequencer.sv
// Scoreboard bench: a driver task pushes the expected outputs after each
// edge, and a monitor pops and compares them shortly after that edge.
module sim_scan_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int H          = 4;     // OSC_HALF
    localparam int SUB        = 15;    // SUBSLOTS
    localparam int BF         = 2;     // BLINK_FRAMES
    localparam int NPH        = 14;    // phases per refresh
    localparam int EXT_P      = 10;    // external clock period in clk cycles

    typedef struct {
        int n;
        int osc;
        int row;
        int bank;
        int dbase;
        int sub;
        int strobe;
        int blink;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_sel = 1'b1;
    logic       ext_clk = 1'b0;
    logic       osc_out;
    logic [2:0] row_idx;
    logic [0:0] bank_idx;
    logic [2:0] digit_base;
    logic [3:0] sub_slot;
    logic       phase_strobe;
    logic       blink;

    exp_t q[$];
    int   n = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    bit   rst_want = 1'b0;
    bit   sel_want = 1'b1;

    scan_sequencer #(
        .OSC_HALF     (H),
        .SUBSLOTS     (SUB),
        .BLINK_FRAMES (BF)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .clk_sel      (clk_sel),
        .ext_clk      (ext_clk),
        .osc_out      (osc_out),
        .row_idx      (row_idx),
        .bank_idx     (bank_idx),
        .digit_base   (digit_base),
        .sub_slot     (sub_slot),
        .phase_strobe (phase_strobe),
        .blink        (blink)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Base ticks consumed after k edges since reset (R2 / R3 latencies).
    function automatic int ticks_after(input int k, input logic sel);
        if (sel) return (k >= H) ? (k - H) / (2 * H) + 1 : 0;
        return (k >= 4) ? (k - 4) / EXT_P + 1 : 0;
    endfunction

    // Driver: account for one edge, push the expectation, then drive inputs.
    task automatic cycle();
        exp_t e;
        int   t;
        int   tp;
        int   ph;
        @(posedge clk);
        if (!rst_n) n = 0; else n = n + 1;
        t  = ticks_after(n, clk_sel);
        tp = (n >= 1) ? ticks_after(n - 1, clk_sel) : 0;
        ph = (t / SUB) % NPH;
        e.n      = n;
        e.osc    = clk_sel ? (n / H) % 2 : 0;
        e.sub    = t % SUB;
        e.bank   = ph % 2;
        e.row    = ph / 2;
        e.dbase  = (ph % 2) * 4;
        e.strobe = (n >= 1 && t != tp && (t % SUB) == 0) ? 1 : 0;
        e.blink  = ((t / (SUB * NPH)) / BF) % 2;
        q.push_back(e);
        @(negedge clk);
        rst_n   = rst_want;
        clk_sel = sel_want;
        ext_clk = (!sel_want && rst_want && n >= 1 && ((n - 1) % EXT_P) < EXT_P / 2);
    endtask

    task automatic run(input int cycles);
        for (int i = 0; i < cycles; i++) cycle();
    endtask

    // One field comparison; the tag names the requirement.
    function automatic bit fld(input string tag, input string name, input int nn,
                               input int act, input int expv);
        if (act != expv) begin
            $display("FAIL %s %s edge=%0d actual=%0d expected=%0d", tag, name, nn, act, expv);
            return 1'b1;
        end
        return 1'b0;
    endfunction

    // Monitor: compare the design against the scoreboard after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                bit   bad;
                e   = q.pop_front();
                bad = 1'b0;
                if (e.n == 0) begin
                    bad |= fld("R1", "osc_out",      e.n, int'(osc_out),      0);
                    bad |= fld("R1", "row_idx",      e.n, int'(row_idx),      0);
                    bad |= fld("R1", "bank_idx",     e.n, int'(bank_idx),     0);
                    bad |= fld("R1", "digit_base",   e.n, int'(digit_base),   0);
                    bad |= fld("R1", "sub_slot",     e.n, int'(sub_slot),     0);
                    bad |= fld("R1", "phase_strobe", e.n, int'(phase_strobe), 0);
                    bad |= fld("R1", "blink",        e.n, int'(blink),        0);
                end else begin
                    bad |= fld(clk_sel ? "R2" : "R3", "osc_out", e.n, int'(osc_out), e.osc);
                    bad |= fld("R4", "sub_slot",     e.n, int'(sub_slot),     e.sub);
                    bad |= fld("R5", "row_idx",      e.n, int'(row_idx),      e.row);
                    bad |= fld("R5", "bank_idx",     e.n, int'(bank_idx),     e.bank);
                    bad |= fld("R6", "digit_base",   e.n, int'(digit_base),   e.dbase);
                    bad |= fld("R7", "phase_strobe", e.n, int'(phase_strobe), e.strobe);
                    bad |= fld("R8", "blink",        e.n, int'(blink),        e.blink);
                end
                n_cmp++;
                if (bad) n_bad++;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (R1..R8 unfinished) actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Stimulus: internal source, mid-run reset, then external source.
    initial begin
        rst_want = 1'b0;
        sel_want = 1'b1;
        run(3);                     // R1 reset state
        rst_want = 1'b1;
        run(7000);                  // R2, R4..R8 with the internal oscillator
        rst_want = 1'b0;
        run(2);                     // R1 mid-run reset
        rst_want = 1'b1;
        run(6000);
        rst_want = 1'b0;
        sel_want = 1'b0;
        run(3);                     // R1 again, switch to external source
        rst_want = 1'b1;
        run(10000);                 // R3 timing, R4..R8 on external ticks
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule